// File: doc/BRIEF.md
# Infrared Carrier Generator

This block produces a square-wave carrier for an infrared transmitter on a single output pin. A free-running up-counter is clocked by the fast oscillator with no prescaler. Each time the counter passes its all-ones value, it restarts from a reload value. The reload value therefore fixes the carrier period at `2^W - reload` clocks.

A second compare register, the duty value, marks where the output falls within each period. The output is high while the count is below the duty value and low from that point up to the wrap. The block raises no interrupt.

Software reaches the block through four write strobes that share one data bus. The strobes load the period, the duty value, the counter itself, and a two-bit control word. The period goes through a holding register, so a rewrite never cuts a period short or stretches it. The carrier reaches the pin only while both control bits are set; otherwise the pin stays low.

Top module: `ircg_carrier_gen`

## Requirements
- R1: After reset, the output is 0 and the counter, the active period, the holding period, the duty value and both control bits are all 0. With duty 5 and both control bits then set, the first 256 clocks give exactly 5 high cycles, and the count that follows restarts at 0.
- R2: The counter advances by one on each clock while control bit 0 (run) is 1. It holds its value while run is 0.
- R3: When the counter is at all-ones and advances, it loads the active period on the next clock. A period value P therefore repeats every 2^W - P clocks.
- R4: A period write lands only in the holding register. The holding value is copied to the active period at the next wrap. That same wrap still reloads the counter from the old active value, so the new period first applies one period later.
- R5: While the carrier is enabled, the output is 1 exactly when count < duty. A period P with duty D > P gives D - P high clocks per period.
- R6: The output is 0 unless control bit 0 (run) and control bit 1 (carrier enable) are both 1. Setting run with carrier enable clear runs the counter but keeps the pin low.
- R7: A counter write sets the count on the next clock. It takes priority over both incrementing and the wrap reload, and a wrap blocked this way commits no period.
- R8: A duty write is not buffered; it changes the compare point on the next clock.
- R9: A duty value at or below the reload value, including 0, keeps the output low for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator clock that drives the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_period | input | 1 | Write strobe for the holding period register |
| wr_duty | input | 1 | Write strobe for the duty compare register |
| wr_count | input | 1 | Write strobe for the counter |
| wr_ctrl | input | 1 | Write strobe for the control bits (bit 0 run, bit 1 carrier enable) |
| wr_data | input | W | Write data shared by all strobes |
| ir_out | output | 1 | Gated carrier output |

## Verification
The hardest state to reach is a wrap that happens while a newly written period still sits in the holding register. Only there do the old reload and the new commit occur in the same clock. The stimulus reaches it by stopping the counter and placing it six counts below the wrap. It then writes a new period and restarts the counter. This makes the first reload, the commit and the later reload visible in a fixed window of high cycles. A second hard case is a counter write that lands exactly on the all-ones count. The bench reaches it by writing all-ones minus one and waiting one clock before the write.

// File: rtl/ircg_pkg.sv
package ircg_pkg;
    localparam int IRCG_CNT_W_DEF = 8;
    localparam int IRCG_CTRL_W    = 2;

    // bit 0 lets the counter run, bit 1 gates the carrier onto the pin
    typedef struct packed {
        logic carrier_en;
        logic run_en;
    } ircg_ctrl_t;
endpackage

// File: rtl/ircg_period_buf.sv
module ircg_period_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         commit,
    output logic [W-1:0] hold_o,
    output logic [W-1:0] active_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
    } pb_state_t;

    pb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the commit reads the hold value from before any same-cycle write
        if (commit) st_d.act  = st_q.hold;
        if (wr_en)  st_d.hold = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o   = st_q.hold;
    assign active_o = st_q.act;
endmodule

// File: rtl/ircg_counter.sv
module ircg_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       at_top;

    assign at_top = (st_q.cnt == CNT_TOP);

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (run) begin
            if (at_top) st_d.cnt = reload_val;
            else        st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = run && !load_en && at_top;
endmodule

// File: rtl/ircg_out_stage.sv
module ircg_out_stage
    import ircg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_duty,
    input  logic         wr_ctrl,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt_i,
    output logic         run_o,
    output logic         carrier_o,
    output logic [W-1:0] duty_o,
    output logic         ir_o
);
    typedef struct packed {
        logic [W-1:0] duty;
        ircg_ctrl_t   ctrl;
    } os_state_t;

    os_state_t st_d, st_q;
    logic      below_duty;

    always_comb begin
        st_d = st_q;
        if (wr_duty) st_d.duty = wr_data;
        if (wr_ctrl) st_d.ctrl = ircg_ctrl_t'(wr_data[IRCG_CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign below_duty = (cnt_i < st_q.duty);
    assign run_o      = st_q.ctrl.run_en;
    assign carrier_o  = st_q.ctrl.carrier_en;
    assign duty_o     = st_q.duty;
    assign ir_o       = st_q.ctrl.run_en && st_q.ctrl.carrier_en && below_duty;
endmodule

// File: rtl/ircg_carrier_gen.sv
module ircg_carrier_gen
    import ircg_pkg::*;
#(
    parameter int W = IRCG_CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_period,
    input  logic         wr_duty,
    input  logic         wr_count,
    input  logic         wr_ctrl,
    input  logic [W-1:0] wr_data,
    output logic         ir_out
);
    logic [W-1:0] cnt_w;
    logic [W-1:0] hold_w;
    logic [W-1:0] act_w;
    logic [W-1:0] duty_w;
    logic         wrap_w;
    logic         run_w;
    logic         carr_w;

    ircg_period_buf #(.W(W)) u_pbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_period),
        .wr_data  (wr_data),
        .commit   (wrap_w),
        .hold_o   (hold_w),
        .active_o (act_w)
    );

    ircg_counter #(.W(W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_w),
        .load_en    (wr_count),
        .load_val   (wr_data),
        .reload_val (act_w),
        .cnt_o      (cnt_w),
        .wrap_o     (wrap_w)
    );

    ircg_out_stage #(.W(W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_duty   (wr_duty),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data),
        .cnt_i     (cnt_w),
        .run_o     (run_w),
        .carrier_o (carr_w),
        .duty_o    (duty_w),
        .ir_o      (ir_out)
    );
endmodule

// File: rtl/ircg_carrier_gen_chk.sv
module ircg_carrier_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_count,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] cnt,
    input logic [W-1:0] hold,
    input logic [W-1:0] act,
    input logic         run,
    input logic         carr,
    input logic         ir_out
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_count && cnt != TOP) |=> (cnt == W'($past(cnt) + 1'b1)));

    assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(cnt));

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_count && cnt == TOP) |=> (cnt == $past(act)));

    assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_count && cnt == TOP) |=> (act == $past(hold)));

    assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && !wr_count && cnt == TOP) |=> $stable(act));

    assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && carr) |-> !ir_out);

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> (cnt == $past(wr_data)));
endmodule

bind ircg_carrier_gen ircg_carrier_gen_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_count (wr_count),
    .wr_data  (wr_data),
    .cnt      (cnt_w),
    .hold     (hold_w),
    .act      (act_w),
    .run      (run_w),
    .carr     (carr_w),
    .ir_out   (ir_out)
);

// File: tb/ircg_carrier_gen_tb_top.sv
`timescale 1ns/1ps
module ircg_carrier_gen_tb_top;
    localparam int K_PER  = 0;
    localparam int K_DUTY = 1;
    localparam int K_CNT  = 2;
    localparam int K_CTRL = 3;

    // vector table: period, duty, expected high clocks over two periods
    localparam int NV = 7;
    localparam int V_P  [NV] = '{0,   200, 250, 100, 240, 128, 254};
    localparam int V_D  [NV] = '{128, 230, 252, 100, 0,   255, 255};
    localparam int V_HI [NV] = '{256, 60,  4,   0,   0,   254, 2};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_period = 1'b0;
    logic       wr_duty = 1'b0;
    logic       wr_count = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ir_out;

    int checks = 0;
    int fails  = 0;
    logic smp [64];

    always #4 clk = ~clk;

    ircg_carrier_gen #(.W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_period (wr_period),
        .wr_duty   (wr_duty),
        .wr_count  (wr_count),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data),
        .ir_out    (ir_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input int kind, input int d);
        wr_data = 8'(d);
        case (kind)
            K_PER:   wr_period = 1'b1;
            K_DUTY:  wr_duty   = 1'b1;
            K_CNT:   wr_count  = 1'b1;
            default: wr_ctrl   = 1'b1;
        endcase
        @(negedge clk);
        wr_period = 1'b0;
        wr_duty   = 1'b0;
        wr_count  = 1'b0;
        wr_ctrl   = 1'b0;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (ir_out) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 output after reset", int'(ir_out), 0);

        // R1: counter and active period start from zero
        wr(K_DUTY, 5);
        wr(K_CTRL, 3);
        count_high(256, hi);
        check("R1 highs in first period", hi, 5);
        check("R1/R3 restart at zero", int'(ir_out), 1);

        // table of period/duty vectors (R3, R5, R9)
        for (int v = 0; v < NV; v++) begin
            wr(K_CTRL, 1);
            wr(K_PER, V_P[v]);
            wr(K_CNT, 255);
            @(negedge clk);              // wrap commits the period
            wr(K_DUTY, V_D[v]);
            wr(K_CTRL, 2);
            wr(K_CNT, V_P[v]);
            wr(K_CTRL, 3);
            count_high(2 * (256 - V_P[v]), hi);
            check($sformatf("R3/R5/R9 vector %0d", v), hi, V_HI[v]);
        end

        // R4: a pending period applies only after one more period (active is 254)
        wr(K_CTRL, 2);
        wr(K_DUTY, 255);
        wr(K_CNT, 250);
        wr(K_PER, 200);
        wr(K_CTRL, 3);
        hi = 0;
        for (int i = 0; i < 64; i++) begin
            smp[i] = ir_out;
            if (ir_out) hi++;
            @(negedge clk);
        end
        check("R4 reload from old active", int'(smp[6]), 1);
        check("R4 old period still used", int'(smp[7]), 0);
        check("R4 highs across commit", hi, 61);

        // R6: both enables needed
        wr(K_CTRL, 2);
        wr(K_CNT, 0);
        check("R6 run off", int'(ir_out), 0);
        wr(K_CTRL, 1);
        count_high(300, hi);
        check("R6 carrier off", hi, 0);
        wr(K_CTRL, 2);
        wr(K_CNT, 0);
        check("R2/R6 held count gated low", int'(ir_out), 0);
        wr(K_CTRL, 3);
        check("R6 both enables", int'(ir_out), 1);

        // R8/R9: duty write takes effect at once; zero duty stays low
        wr(K_DUTY, 0);
        check("R8 duty change next clock", int'(ir_out), 0);
        count_high(300, hi);
        check("R9 zero duty", hi, 0);

        // R7: counter write while running, including at the wrap point
        wr(K_DUTY, 100);
        wr(K_CNT, 150);
        check("R7 load above duty", int'(ir_out), 0);
        wr(K_CNT, 50);
        check("R7 load below duty", int'(ir_out), 1);
        wr(K_CNT, 254);
        @(negedge clk);
        wr(K_CNT, 30);
        check("R7 load beats wrap", int'(ir_out), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule